// File: doc/BRIEF.md
# Cascadable TDM256 Serializer

This block drives one serial data line that carries eight time slots per frame. The bit clock runs at 256 times the sample rate, so each slot is 32 bit clocks long and holds a 24-bit two's complement sample, most significant bit first. Each device places its own left and right samples in the first two slots. It forwards the stream arriving on its cascade input into the remaining six slots, delayed by exactly two slots.

Up to four identical devices can be chained. Each device's serial output feeds the cascade input of the next, and the first device has its cascade input tied low. The last device then emits the left and right samples of device 4, 3, 2 and 1 in that order. Two mode inputs select the framing. One picks master operation, where the block produces the frame marker itself, or slave operation, where the block follows an external frame clock. The other picks MSB-justified framing or I2S framing, in which every slot's data starts one bit clock late. The block runs on the rising edge of the bit clock, which is its `clk` input.

Top module: `tdm_cascade_serializer`

## Requirements
- R1: A frame is 256 bit clocks long: eight slots of 32 bit clocks. Frame position 0 is the first bit clock of slot 0. In master mode a new frame begins every 256 bit clocks.
- R2: `frameOut` is driven only in master mode. With MSB-justified framing it is high for frame positions 0 to 31 and low otherwise. With I2S framing it is the inverse of that. In slave mode it stays low.
- R3: With MSB-justified framing, slot 0 (positions 0 to 31) carries the captured left sample. Slot bit 0 carries sample bit 23, down to slot bit 23, which carries sample bit 0. Slot bits 24 to 31 are 0.
- R4: Slot 1 (positions 32 to 63) carries the captured right sample, laid out the same way as slot 0.
- R5: With I2S framing, each local slot is shifted one bit clock later. Slot bit 0 is 0, slot bits 1 to 24 carry sample bits 23 down to 0, and slot bits 25 to 31 are 0.
- R6: At positions 64 to 255, `serOut` equals the value that `cascadeIn` had at the rising edge 64 bit clocks earlier.
- R7: Both samples are captured at the rising edge that starts a frame (position 0). Later changes of `leftSample` or `rightSample` do not affect the frame in progress.
- R8: In slave mode, the frame position returns to 0 at the first rising edge where `frameIn` is seen high after being low (MSB-justified framing) or low after being high (I2S framing). This happens even in the middle of a frame.
- R9: While `rstN` is low, `serOut` is 0 and the delay line is cleared. After reset, the first rising edge starts a frame.
- R10: In a chain of four devices, where the first device's `cascadeIn` is tied to 0, the last device emits L4, R4, L3, R3, L2, R2, L1, R1 in slots 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (256 per frame); all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| masterSel | input | 1 | 1: block generates frame marker; 0: follows `frameIn` |
| i2sSel | input | 1 | 1: I2S framing; 0: MSB-justified framing |
| frameIn | input | 1 | External frame clock, used in slave mode |
| frameOut | output | 1 | Generated frame marker in master mode, 0 in slave mode |
| leftSample | input | 24 | Local left sample, two's complement |
| rightSample | input | 24 | Local right sample, two's complement |
| cascadeIn | input | 1 | Serial TDM stream from the upstream device |
| serOut | output | 1 | Serial TDM output |

## Verification
The bench builds four copies of the block with the default parameters: 24-bit samples, 32-bit slots, eight slots per frame and two local slots. These are wired into a full four-device chain, so every slot of the last device carries a real sample. Because of this, the two-slot delay, the slot ordering across devices and the padding are all visible at a single output. The fixed 256-clock frame lets short runs cover several whole frames in each framing and mode. Mid-frame sample changes and early slave frame edges then land at arbitrary positions.

// File: rtl/tdm_cascade_pkg.sv
package tdm_cascade_pkg;
  parameter int SAMPLE_W    = 24;
  parameter int SLOT_W      = 32;
  parameter int SLOT_CNT    = 8;
  parameter int LOCAL_SLOTS = 2;

  localparam int FRAME_LEN   = SLOT_W * SLOT_CNT;
  localparam int POS_W       = $clog2(FRAME_LEN);
  localparam int SLOT_BITS_W = $clog2(SLOT_W);
  localparam int DELAY_LEN   = SLOT_W * LOCAL_SLOTS;
  localparam int DATA_IDX_W  = $clog2(SAMPLE_W);
  localparam int CH_W        = $clog2(LOCAL_SLOTS);

  typedef struct packed {
    logic                  frameStart;
    logic                  localZone;
    logic [CH_W-1:0]       chanSel;
    logic                  dataValid;
    logic [DATA_IDX_W-1:0] dataIdx;
  } slotStrobes_t;
endpackage

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl
  import tdm_cascade_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterSel,
  input  logic             i2sSel,
  input  logic             frameIn,
  output logic             frameOut,
  output logic [POS_W-1:0] bitPos,
  output slotStrobes_t     strobes
);
  logic             frameQ;
  logic             syncEdge;
  logic [POS_W-1:0] nextPos;

  // Slave sync: edge polarity follows the framing.
  always_comb begin
    syncEdge = !masterSel && (i2sSel ? (frameQ && !frameIn) : (!frameQ && frameIn));
    if (syncEdge)
      nextPos = '0;
    else if (bitPos == POS_W'(FRAME_LEN - 1))
      nextPos = '0;
    else
      nextPos = bitPos + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitPos <= POS_W'(FRAME_LEN - 1);
      frameQ <= 1'b0;
    end else begin
      bitPos <= nextPos;
      frameQ <= frameIn;
    end
  end

  // Per-position strobes for the datapath.
  always_comb begin
    int slotBitI;
    int leadI;
    int offI;
    slotBitI = int'(bitPos[SLOT_BITS_W-1:0]);
    leadI    = i2sSel ? 1 : 0;
    offI     = slotBitI - leadI;
    strobes.frameStart = (nextPos == '0);
    strobes.localZone  = (bitPos < POS_W'(DELAY_LEN));
    strobes.chanSel    = bitPos[SLOT_BITS_W +: CH_W];
    strobes.dataValid  = (offI >= 0) && (offI < SAMPLE_W);
    if (strobes.dataValid)
      strobes.dataIdx = DATA_IDX_W'(SAMPLE_W - 1 - offI);
    else
      strobes.dataIdx = '0;
  end

  assign frameOut = masterSel && ((bitPos < POS_W'(SLOT_W)) ^ i2sSel);
endmodule

// File: rtl/tdm_slot_datapath.sv
module tdm_slot_datapath
  import tdm_cascade_pkg::*;
(
  input  logic                                   clk,
  input  logic                                   rstN,
  input  slotStrobes_t                           strobes,
  input  logic [LOCAL_SLOTS-1:0][SAMPLE_W-1:0]   localSamples,
  input  logic                                   cascadeIn,
  output logic                                   serOut,
  output logic [LOCAL_SLOTS-1:0][SAMPLE_W-1:0]   heldSamples
);
  logic [DELAY_LEN-1:0]   dly;
  logic [LOCAL_SLOTS-1:0] chanBit;
  logic                   localBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldSamples <= '0;
      dly         <= '0;
    end else begin
      if (strobes.frameStart) heldSamples <= localSamples;
      dly <= {dly[DELAY_LEN-2:0], cascadeIn};
    end
  end

  // One bit picker per local channel.
  for (genvar ch = 0; ch < LOCAL_SLOTS; ch++) begin : g_pick
    assign chanBit[ch] = heldSamples[ch][strobes.dataIdx];
  end

  assign localBit = strobes.dataValid & chanBit[strobes.chanSel];
  assign serOut   = strobes.localZone ? localBit : dly[DELAY_LEN-1];
endmodule

// File: rtl/tdm_cascade_serializer.sv
module tdm_cascade_serializer
  import tdm_cascade_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                masterSel,
  input  logic                i2sSel,
  input  logic                frameIn,
  output logic                frameOut,
  input  logic [SAMPLE_W-1:0] leftSample,
  input  logic [SAMPLE_W-1:0] rightSample,
  input  logic                cascadeIn,
  output logic                serOut
);
  slotStrobes_t                         strobes;
  logic [POS_W-1:0]                     bitPos;
  logic [LOCAL_SLOTS-1:0][SAMPLE_W-1:0] localSamples;
  logic [LOCAL_SLOTS-1:0][SAMPLE_W-1:0] heldSamples;

  assign localSamples[0] = leftSample;
  assign localSamples[1] = rightSample;

  tdm_frame_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .masterSel (masterSel),
    .i2sSel    (i2sSel),
    .frameIn   (frameIn),
    .frameOut  (frameOut),
    .bitPos    (bitPos),
    .strobes   (strobes)
  );

  tdm_slot_datapath u_data (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .localSamples (localSamples),
    .cascadeIn    (cascadeIn),
    .serOut       (serOut),
    .heldSamples  (heldSamples)
  );
endmodule

// File: rtl/tdm_cascade_checker.sv
module tdm_cascade_checker
  import tdm_cascade_pkg::*;
(
  input logic                                 clk,
  input logic                                 rstN,
  input logic                                 masterSel,
  input logic                                 i2sSel,
  input logic                                 frameIn,
  input logic                                 frameOut,
  input logic                                 serOut,
  input logic                                 frameStart,
  input logic [POS_W-1:0]                     bitPos,
  input logic [LOCAL_SLOTS-1:0][SAMPLE_W-1:0] heldSamples
);
  logic [POS_W-1:0] sinceStart;
  logic             seenStart;
  logic             armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceStart <= '0;
      seenStart  <= 1'b0;
      armed      <= 1'b0;
    end else begin
      sinceStart <= frameStart ? '0 : sinceStart + 1'b1;
      if (frameStart) seenStart <= 1'b1;
      armed <= 1'b1;
    end
  end

  // R1: master frames are exactly FRAME_LEN bit clocks apart
  a_r1_frame_length: assert property (@(posedge clk) disable iff (!rstN)
    (masterSel && frameStart && seenStart) |-> (sinceStart == POS_W'(FRAME_LEN - 1)));

  // R2: no frame marker in slave mode
  a_r2_slave_marker_low: assert property (@(posedge clk) disable iff (!rstN)
    !masterSel |-> !frameOut);

  // R3: padding bits of local slots are zero in MSB-justified framing
  a_r3_msb_padding: assert property (@(posedge clk) disable iff (!rstN)
    (!i2sSel && bitPos < POS_W'(DELAY_LEN) &&
     int'(bitPos[SLOT_BITS_W-1:0]) >= SAMPLE_W) |-> !serOut);

  // R5: I2S lead bit of each local slot is zero
  a_r5_i2s_lead_bit: assert property (@(posedge clk) disable iff (!rstN)
    (i2sSel && bitPos < POS_W'(DELAY_LEN) && bitPos[SLOT_BITS_W-1:0] == '0) |-> !serOut);

  // R7: captured samples only move at a frame start
  a_r7_hold_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(heldSamples));

  // R8: slave resync on rising frame clock (MSB-justified)
  a_r8_sync_rise: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !masterSel && !i2sSel && frameIn && !$past(frameIn)) |=> (bitPos == '0));

  // R8: slave resync on falling frame clock (I2S)
  a_r8_sync_fall: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !masterSel && i2sSel && !frameIn && $past(frameIn)) |=> (bitPos == '0));

  // R9: output quiet while in reset
  always @(negedge clk) begin
    if (!rstN) begin
      a_r9_quiet_in_reset: assert (serOut == 1'b0) else $error("serOut high during reset");
    end
  end
endmodule

bind tdm_cascade_serializer tdm_cascade_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .masterSel   (masterSel),
  .i2sSel      (i2sSel),
  .frameIn     (frameIn),
  .frameOut    (frameOut),
  .serOut      (serOut),
  .frameStart  (strobes.frameStart),
  .bitPos      (bitPos),
  .heldSamples (heldSamples)
);

// File: tb/tb_tdm_cascade_serializer.sv
module tb_tdm_cascade_serializer;
  import tdm_cascade_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, masterSel, i2sSel, frameIn;
  logic [SAMPLE_W-1:0] smpL [4];
  logic [SAMPLE_W-1:0] smpR [4];
  logic c01, c12, c23, sOut;
  logic fo0, fo1, fo2, foD;

  tdm_cascade_serializer u0 (.clk(clk), .rstN(rstN), .masterSel(masterSel), .i2sSel(i2sSel),
    .frameIn(frameIn), .frameOut(fo0), .leftSample(smpL[0]), .rightSample(smpR[0]),
    .cascadeIn(1'b0), .serOut(c01));
  tdm_cascade_serializer u1 (.clk(clk), .rstN(rstN), .masterSel(masterSel), .i2sSel(i2sSel),
    .frameIn(frameIn), .frameOut(fo1), .leftSample(smpL[1]), .rightSample(smpR[1]),
    .cascadeIn(c01), .serOut(c12));
  tdm_cascade_serializer u2 (.clk(clk), .rstN(rstN), .masterSel(masterSel), .i2sSel(i2sSel),
    .frameIn(frameIn), .frameOut(fo2), .leftSample(smpL[2]), .rightSample(smpR[2]),
    .cascadeIn(c12), .serOut(c23));
  tdm_cascade_serializer dut (.clk(clk), .rstN(rstN), .masterSel(masterSel), .i2sSel(i2sSel),
    .frameIn(frameIn), .frameOut(foD), .leftSample(smpL[3]), .rightSample(smpR[3]),
    .cascadeIn(c23), .serOut(sOut));

  int nChecks = 0;
  int nErr = 0;
  bit chkOn = 1'b0;
  string phaseTag = "";

  // Reference model: frame position and captured samples per device.
  int pos = 255;
  logic prevF = 1'b0;
  logic [SAMPLE_W-1:0] latL [4];
  logic [SAMPLE_W-1:0] latR [4];

  always @(posedge clk) begin
    if (!rstN) begin
      pos = FRAME_LEN - 1;
      prevF = 1'b0;
      for (int i = 0; i < 4; i++) begin latL[i] = '0; latR[i] = '0; end
    end else begin
      bit se;
      se = !masterSel && (i2sSel ? (prevF && !frameIn) : (!prevF && frameIn));
      pos = se ? 0 : (pos + 1) % FRAME_LEN;
      if (pos == 0)
        for (int i = 0; i < 4; i++) begin latL[i] = smpL[i]; latR[i] = smpR[i]; end
      prevF = frameIn;
    end
  end

  function automatic logic expBit(int p);
    int s, b, k, d;
    logic [SAMPLE_W-1:0] w;
    s = p / SLOT_W;
    b = p % SLOT_W;
    k = 3 - s / 2;
    d = i2sSel ? b - 1 : b;
    w = (s % 2 == 1) ? latR[k] : latL[k];
    if (d < 0 || d >= SAMPLE_W) return 1'b0;
    return w[SAMPLE_W-1-d];
  endfunction

  function automatic string tagFor(int p);
    string t;
    if (!rstN) return "R9";
    if (p >= DELAY_LEN) t = "R6,R10";
    else if (i2sSel) t = "R5";
    else if (p < SLOT_W) t = "R3";
    else t = "R4";
    if (phaseTag != "") t = {t, ",", phaseTag};
    return t;
  endfunction

  task automatic check(logic act, logic exp, string tag);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %b expected %b (frame position %0d)", tag, act, exp, pos);
    end
  endtask

  int cycN = 0;
  int lastStart = -1;
  logic prevFo = 1'b0;

  always @(negedge clk) begin
    cycN++;
    if (chkOn) begin
      check(sOut, rstN ? expBit(pos) : 1'b0, tagFor(pos));
      if (rstN) check(foD, masterSel ? ((pos < SLOT_W) ^ i2sSel) : 1'b0, "R2");
      if (!rstN) lastStart = -1;
      else if (masterSel && foD != prevFo && foD == !i2sSel) begin
        if (lastStart >= 0) check(1'((cycN - lastStart) == FRAME_LEN), 1'b1, "R1");
        lastStart = cycN;
      end
    end
    prevFo = foD;
  end

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    nErr++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  int fpos = 0;

  task automatic step(bit slave);
    @(negedge clk);
    #2;
    for (int i = 0; i < 4; i++) begin
      if ($urandom_range(0, 40) == 0) smpL[i] = SAMPLE_W'($urandom);
      if ($urandom_range(0, 40) == 0) smpR[i] = SAMPLE_W'($urandom);
    end
    if (slave) begin
      fpos = (fpos + 1) % FRAME_LEN;
      frameIn = i2sSel ? (fpos >= FRAME_LEN / 2) : (fpos < FRAME_LEN / 2);
    end
  endtask

  task automatic doReset(bit m, bit i2s);
    @(negedge clk);
    #2;
    rstN = 1'b0;
    masterSel = m;
    i2sSel = i2s;
    fpos = 130;
    frameIn = i2s ? 1'b1 : 1'b0;
    repeat (3) step(1'b0);
    @(negedge clk);
    #2;
    rstN = 1'b1;
  endtask

  task automatic slavePhase(bit i2s);
    phaseTag = "";
    doReset(1'b0, i2s);
    repeat (600) step(1'b1);
    // Early frame edge mid-frame: jump the frame clock generator
    while (fpos < 200) step(1'b1);
    phaseTag = "R8";
    fpos = FRAME_LEN - 1;
    repeat (700) step(1'b1);
  endtask

  initial begin
    rstN = 1'b0;
    masterSel = 1'b1;
    i2sSel = 1'b0;
    frameIn = 1'b0;
    for (int i = 0; i < 4; i++) begin
      smpL[i] = SAMPLE_W'($urandom);
      smpR[i] = SAMPLE_W'($urandom);
    end
    repeat (2) @(negedge clk);
    chkOn = 1'b1;
    // R9: reset state observed for a few cycles
    repeat (4) step(1'b0);
    @(negedge clk);
    #2;
    rstN = 1'b1;
    // Master, MSB-justified, samples changing mid-frame (R7)
    phaseTag = "R7";
    repeat (900) step(1'b0);
    // Master, I2S framing
    phaseTag = "";
    doReset(1'b1, 1'b1);
    repeat (900) step(1'b0);
    // Slave modes with resync
    slavePhase(1'b0);
    slavePhase(1'b1);
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule